// File: doc/BRIEF.md
# Virtual Data Plane Selector

The selector sits at the front of a shared packet pipeline that hosts several independent data planes. Each Ethernet frame arrives as a byte stream with start and end markers. The selector reads the destination MAC address (the first six bytes) and looks it up in a small table that software fills in. The result chooses a plane. A 64-bit control header is then placed in front of the frame, and the following pipeline stages steer on it.

The header holds four fields: a 32-bit hash, a 16-bit bitmap of the preprocessing modules to enable, an 8-bit forwarding mode and the 8-bit plane number. The bitmap, the mode and the hash byte-selection mask are per-plane registers. The hash is a CRC-32 over the header bytes that the plane's mask selects, taken from the first 32 bytes of the frame.

Up to 32 leading bytes are held in a local buffer until the MAC address and all hashable bytes have been seen. The block then computes the hash and emits the header, then the buffered bytes, then the rest of the frame straight through. Output back-pressure is honoured in every phase.

Top module: `vdp_selector`

## Requirements
- R1: While no frame is in progress, an input byte without `in_sof` is accepted and discarded. It produces no output.
- R2: Each output frame is the 8-byte header, then every input byte of the frame unchanged and in order. The header is sent most significant byte first with hash in bits 63:32, bitmap in 31:16, mode in 15:8 and plane number in 7:0. `out_sof` marks the first header byte and `out_eof` marks the last frame byte.
- R3: The destination MAC is frame bytes 0 to 5, with byte 0 most significant. It is compared with every valid table entry, and a match gives the entry's plane number.
- R4: A frame whose MAC matches no usable entry goes to plane 0. An entry that matches but names a plane of NUM_PLANES or above is ignored.
- R5: When several usable entries match, the one with the lowest index decides the plane.
- R6: The bitmap and mode in the header are the register values of the selected plane.
- R7: The hash is a CRC-32 with polynomial 0x04C11DB7 and initial value 0xFFFFFFFF, processed MSB first, with no final inversion. It runs in byte order over the bytes k < 32 whose bit k is set in the selected plane's mask. With no byte selected the hash is 0xFFFFFFFF.
- R8: In a frame shorter than 32 bytes, only the bytes present are hashed. MAC bytes beyond the frame end read as zero for the lookup.
- R9: While `out_ready` is low, a presented output beat holds its data and markers. No byte is lost or duplicated under back-pressure or gaps in the input.
- R10: Register writes use `cfg_addr[7:6]` as region and `cfg_addr[5:0]` as index. Region 0 writes a MAC entry: MAC in `cfg_wdata[47:0]`, plane in `[55:48]`, valid in `[63]`. Region 1 writes a plane's bitmap in `[15:0]` and mode in `[23:16]`. Region 2 writes a plane's hash mask in `[31:0]`, where bit k selects byte k.
- R11: After reset, all table entries are invalid and all plane registers are zero. No output is presented and input is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register region and index |
| cfg_wdata | input | 64 | Register write data |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte taken |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of an input frame |
| in_eof | input | 1 | Last byte of an input frame |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of an output frame |
| out_eof | output | 1 | Last byte of an output frame |

## Verification
The bench sends frames that hit, miss and doubly hit the table. One entry names an out-of-range plane. A design that stopped at the first raw match, or that took the highest index, would stamp the wrong plane number and registers into the header.

Frame lengths of 1, 4, 32, 33 and 64 bytes test the buffer boundary. An off-by-one there would drop or repeat the byte at position 31 or 32, or hash bytes left over from an earlier frame.

Random output stalls and input gaps are applied throughout. A design that advanced on a stalled beat would skip header bytes, and stray bytes sent between frames would appear as a spurious frame if the start marker were ignored.

// File: rtl/vdp_selector.sv
module vdp_selector #(
  parameter int NUM_PLANES = 4,
  parameter int NUM_MACS   = 8,
  parameter int HASH_BYTES = 32,
  localparam int PW = $clog2(NUM_PLANES),
  localparam int BW = $clog2(HASH_BYTES),
  localparam int CW = $clog2(HASH_BYTES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_addr,
  input  logic [63:0] cfg_wdata,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_sof,
  output logic        out_eof
);
  localparam logic [31:0] POLY = 32'h04C11DB7;
  typedef enum logic [2:0] {S_CAP, S_HASH, S_HDR, S_BUF, S_PASS} st_t;

  st_t st;
  logic [47:0] mac_tab [NUM_MACS];
  logic [7:0]  mac_pid [NUM_MACS];
  logic        mac_ok  [NUM_MACS];
  logic [15:0] bm_r  [NUM_PLANES];
  logic [7:0]  md_r  [NUM_PLANES];
  logic [HASH_BYTES-1:0] msk_r [NUM_PLANES];
  logic [7:0]  buf_r [HASH_BYTES];
  logic [CW-1:0] cnt, idx;
  logic        ended;
  logic [31:0] crc;
  logic [47:0] mac_w;
  logic [PW-1:0] pid;
  logic [63:0] hdr;
  logic        unused_cfg;

  assign unused_cfg = ^cfg_wdata;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 7; b >= 0; b--) r = {r[30:0], 1'b0} ^ ((r[31] ^ d[b]) ? POLY : 32'h0);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_MACS; i++) begin
        mac_ok[i] <= 1'b0; mac_tab[i] <= '0; mac_pid[i] <= '0;
      end
      for (int i = 0; i < NUM_PLANES; i++) begin
        bm_r[i] <= '0; md_r[i] <= '0; msk_r[i] <= '0;
      end
    end else if (cfg_we) begin
      for (int i = 0; i < NUM_MACS; i++)
        if (cfg_addr[7:6] == 2'd0 && cfg_addr[5:0] == 6'(i)) begin
          mac_tab[i] <= cfg_wdata[47:0];
          mac_pid[i] <= cfg_wdata[55:48];
          mac_ok[i]  <= cfg_wdata[63];
        end
      for (int i = 0; i < NUM_PLANES; i++) begin
        if (cfg_addr[7:6] == 2'd1 && cfg_addr[5:0] == 6'(i)) begin
          bm_r[i] <= cfg_wdata[15:0];
          md_r[i] <= cfg_wdata[23:16];
        end
        if (cfg_addr[7:6] == 2'd2 && cfg_addr[5:0] == 6'(i))
          msk_r[i] <= cfg_wdata[HASH_BYTES-1:0];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < 6; k++)
      mac_w[8*(5-k) +: 8] = (CW'(k) < cnt) ? buf_r[k] : 8'h00;
  end

  always_comb begin
    pid = '0;
    for (int i = NUM_MACS - 1; i >= 0; i--)
      if (mac_ok[i] && mac_tab[i] == mac_w && mac_pid[i] < 8'(NUM_PLANES))
        pid = mac_pid[i][PW-1:0];
  end

  assign hdr = {crc, bm_r[pid], md_r[pid], 8'(pid)};

  wire cap_acc = (st == S_CAP) && in_valid && (cnt != '0 || in_sof);

  always_ff @(posedge clk) if (cap_acc) buf_r[cnt[BW-1:0]] <= in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_CAP; cnt <= '0; idx <= '0; ended <= 1'b0; crc <= '1;
    end else begin
      case (st)
        S_CAP: if (cap_acc) begin
          cnt <= cnt + 1'b1;
          if (in_eof || cnt == CW'(HASH_BYTES - 1)) begin
            ended <= in_eof; st <= S_HASH; idx <= '0; crc <= '1;
          end
        end
        S_HASH: begin
          if (idx < cnt && msk_r[pid][idx[BW-1:0]]) crc <= crc_byte(crc, buf_r[idx[BW-1:0]]);
          idx <= idx + 1'b1;
          if (idx == CW'(HASH_BYTES - 1)) begin st <= S_HDR; idx <= '0; end
        end
        S_HDR: if (out_ready) begin
          idx <= idx + 1'b1;
          if (idx == CW'(7)) begin st <= S_BUF; idx <= '0; end
        end
        S_BUF: if (out_ready) begin
          idx <= idx + 1'b1;
          if (idx == cnt - 1'b1) begin
            st <= ended ? S_CAP : S_PASS; cnt <= '0; idx <= '0;
          end
        end
        S_PASS: if (in_valid && out_ready && in_eof) st <= S_CAP;
        default: st <= S_CAP;
      endcase
    end
  end

  assign in_ready  = (st == S_CAP) || (st == S_PASS && out_ready);
  assign out_valid = (st == S_HDR) || (st == S_BUF) || (st == S_PASS && in_valid);
  assign out_sof   = (st == S_HDR) && idx == '0;
  assign out_eof   = (st == S_BUF && ended && idx == cnt - 1'b1) || (st == S_PASS && in_eof);
  assign out_data  = (st == S_HDR) ? hdr[8*(7 - idx[2:0]) +: 8] :
                     (st == S_BUF) ? buf_r[idx[BW-1:0]] : in_data;
endmodule

// File: rtl/vdp_selector_chk.sv
module vdp_selector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic       out_eof
);
  logic in_frame;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) in_frame <= 1'b0;
    else if (out_valid && out_ready) in_frame <= !out_eof;

  // R2
  frame_start_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !in_frame |-> out_sof);
  // R2
  no_mid_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && in_frame |-> !out_sof);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_eof) && $stable(out_sof));
  // R2
  header_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> !in_ready);
  // R11
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !out_valid && in_ready);
endmodule

bind vdp_selector vdp_selector_chk u_chk (.*);

// File: tb/vdp_selector_bench.sv
`timescale 1ns/1ps
module vdp_selector_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [7:0] cfg_addr = 0; logic [63:0] cfg_wdata = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0; logic [7:0] in_data = 0;
  logic out_ready = 1;
  logic in_ready, out_valid, out_sof, out_eof; logic [7:0] out_data;

  vdp_selector u_vdp_selector (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0, bp = 0, gaps = 0;
  logic [15:0] lfsr = 16'hACE1;
  string cur_req = "R2";
  logic [9:0] exp_q[$];
  logic [47:0] m_mac[8]; logic [7:0] m_pid[8]; bit m_ok[8];
  logic [15:0] m_bm[4]; logic [7:0] m_md[4]; logic [31:0] m_msk[4];

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_mac[i] = 0; m_pid[i] = 0; m_ok[i] = 0; end
    for (int i = 0; i < 4; i++) begin m_bm[i] = 0; m_md[i] = 0; m_msk[i] = 0; end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= bp ? (lfsr[0] | lfsr[5]) : 1'b1;
  end

  initial forever begin
    @(negedge clk); #2;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL %s actual=%h expected=none (unexpected beat)", cur_req, {out_sof, out_eof, out_data});
      end else
        check(cur_req, {out_sof, out_eof, out_data}, exp_q.pop_front());
    end
  end

  task automatic cfg_write(logic [7:0] a, logic [63:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    case (a[7:6])
      2'd0: begin m_mac[a[2:0]] = d[47:0]; m_pid[a[2:0]] = d[55:48]; m_ok[a[2:0]] = d[63]; end
      2'd1: begin m_bm[a[1:0]] = d[15:0]; m_md[a[1:0]] = d[23:16]; end
      2'd2: m_msk[a[1:0]] = d[31:0];
      default: ;
    endcase
  endtask

  function automatic logic [31:0] ref_crc(logic [7:0] f[$], logic [31:0] m);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < 32 && k < f.size(); k++)
      if (m[k])
        for (int b = 7; b >= 0; b--) begin
          bit top = c[31] ^ f[k][b];
          c = c << 1;
          if (top) c = c ^ 32'h04C11DB7;
        end
    return c;
  endfunction

  task automatic send_frame(logic [7:0] f[$]);
    logic [47:0] mac = 0; int pl = 0; bit found = 0; logic [63:0] h;
    for (int k = 0; k < 6; k++) mac = {mac[39:0], (k < f.size()) ? f[k] : 8'h00};
    for (int i = 0; i < 8; i++)
      if (!found && m_ok[i] && m_mac[i] == mac && m_pid[i] < 4) begin pl = m_pid[i]; found = 1; end
    h = {ref_crc(f, m_msk[pl]), m_bm[pl], m_md[pl], 8'(pl)};
    for (int k = 0; k < 8; k++) exp_q.push_back({(k == 0), 1'b0, h[8*(7-k) +: 8]});
    for (int k = 0; k < f.size(); k++) exp_q.push_back({1'b0, (k == f.size() - 1), f[k]});
    for (int k = 0; k < f.size(); k++) begin
      if (gaps && lfsr[3]) begin in_valid = 0; @(negedge clk); end
      in_valid = 1; in_data = f[k]; in_sof = (k == 0); in_eof = (k == f.size() - 1);
      #2; while (!in_ready) begin @(negedge clk); #2; end
      @(negedge clk);
    end
    in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  function automatic void mk(ref logic [7:0] f[$], input logic [47:0] mac, int len, int seed);
    f.delete();
    for (int k = 0; k < len; k++) f.push_back(k < 6 ? mac[8*(5-k) +: 8] : 8'(seed + 7 * k));
  endfunction

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 2000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    check({cur_req, " drain"}, exp_q.size(), 0);
  endtask

  localparam logic [47:0] MA = 48'h0A1B2C3D4E5F, MB = 48'h0000DEADBEEF,
                          MC = 48'h112233445566, MD = 48'h665544332211,
                          MS = 48'hC0FFEE120000, MX = 48'hFFFFFFFFFFFF;

  initial begin
    logic [7:0] f[$];
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check("R11 out_valid", out_valid, 0);
    check("R11 in_ready", in_ready, 1);
    @(negedge clk);

    cur_req = "R11"; mk(f, MA, 10, 3); send_frame(f); drain();

    cfg_write(8'h00, {1'b1, 7'd0, 8'd2, MA});
    cfg_write(8'h01, {1'b1, 7'd0, 8'd1, MB});
    cfg_write(8'h02, {1'b1, 7'd0, 8'd3, MB});
    cfg_write(8'h03, {1'b1, 7'd0, 8'd7, MC});
    cfg_write(8'h04, {1'b0, 7'd0, 8'd3, MD});
    cfg_write(8'h05, {1'b1, 7'd0, 8'd3, MS});
    for (int p = 0; p < 4; p++) cfg_write(8'h40 + 8'(p), {40'h0, 8'h10 + 8'(p), 16'hA000 + 16'(p * 257)});
    cfg_write(8'h80, 64'h0000_00FF);
    cfg_write(8'h81, 64'hFFFF_FFFF);
    cfg_write(8'h82, 64'h8000_0F3C);
    cfg_write(8'h83, 64'h0000_300F);

    @(negedge clk); cur_req = "R1";
    for (int k = 0; k < 3; k++) begin in_valid = 1; in_data = 8'h55 + 8'(k); @(negedge clk); end
    in_valid = 0;
    mk(f, MA, 40, 9); send_frame(f); drain();

    cur_req = "R3"; mk(f, MA, 64, 1); send_frame(f); drain();
    cur_req = "R5"; mk(f, MB, 20, 2); send_frame(f); drain();
    cur_req = "R4"; mk(f, MC, 12, 4); send_frame(f); drain();
    cur_req = "R4"; mk(f, MD, 33, 5); send_frame(f); drain();
    cur_req = "R4"; mk(f, MX, 64, 6); send_frame(f); drain();
    cur_req = "R8"; mk(f, MS, 4, 0); send_frame(f); drain();
    cur_req = "R8"; mk(f, MS, 1, 0); send_frame(f); drain();
    cur_req = "R7"; mk(f, MB, 32, 8); send_frame(f); drain();
    cur_req = "R6"; cfg_write(8'h42, 64'h00_5A_C3C3); mk(f, MA, 33, 11); send_frame(f); drain();

    cur_req = "R9"; bp = 1; gaps = 1;
    mk(f, MA, 50, 12); send_frame(f);
    mk(f, MB, 32, 13); send_frame(f);
    mk(f, MS, 5, 14); send_frame(f);
    mk(f, MC, 70, 15); send_frame(f);
    drain();
    bp = 0; gaps = 0;
    cur_req = "R10"; cfg_write(8'h00, {1'b0, 7'd0, 8'd2, MA}); mk(f, MA, 8, 16); send_frame(f); drain();
    @(negedge clk); #1;
    check("R11 idle in_ready", in_ready, 1);
    check("R2 idle out_valid", out_valid, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule